// File: doc/BRIEF.md
# Cartridge Slot Power and Controller Select

This block manages a removable cartridge slot. A control register picks which of three card interface controllers owns the slot, and a one-hot decode enables that controller's register window. A separate control bit routes the slot to a serial save-memory (SPI) interface instead.

A status register reports whether a card is present and holds a two-bit supply state. Software moves the supply forward by writing this field: off, then regulator preparing, then output on, then power-down requested. Once a power-down is requested, a timer returns the supply to off after `OFF_DELAY` clock cycles with no further write. If the card is pulled out while the supply is preparing or on, the block forces the power-down request state on its own. The block drives two supply outputs: one enables the regulator and one closes the slot output switch.

Top module: `cart_slot_ctl`

## Requirements
- R1: Control bits 1:0 select the owning controller. Value 0 drives `win_en[0]` (legacy interface), value 2 drives `win_en[1]` (new controller 0) and value 3 drives `win_en[2]` (new controller 1). Value 1 enables no window.
- R2: At most one window enable is high at any time. A control write changes the enables on the clock edge that captures it.
- R3: Control bit 8 drives `spi_mode`, which goes high when the slot is routed to the serial save-memory interface.
- R4: Status bit 0 reads 1 when `card_present` is low (slot empty) and 0 when it is high. The bit follows the input in the same cycle.
- R5: Status bits 3:2 read the supply state, encoded as 0 off, 1 preparing, 2 on and 3 power-down requested. All other status bits read 0.
- R6: A status write loads bits 3:2 into the supply state on the next edge. The one exception is a write of 2 while the state is 0, which is ignored.
- R7: State 3 lasts exactly `OFF_DELAY` cycles and then becomes 0. Status writes made during state 3 are ignored.
- R8: If `card_present` is low while the state is 1 or 2, the state becomes 3 on the next edge. This takes priority over any status write in the same cycle.
- R9: `reg_en` is high in states 1 and 2. `out_en` is high only in state 2.
- R10: After reset the supply state is 0, the select field is 0 (so the legacy window is enabled) and `spi_mode` is 0.
- R11: A control read returns the select field in bits 1:0 and the SPI bit in bit 8. All other control bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write target: 0 control, 1 status |
| wr_data | input | DW | Write data |
| rd_addr | input | 1 | Read target: 0 control, 1 status |
| rd_data | output | DW | Read data (combinational) |
| card_present | input | 1 | High while a card is inserted |
| win_en | output | 3 | One-hot window enable per controller |
| spi_mode | output | 1 | Slot routed to the SPI save interface |
| reg_en | output | 1 | Regulator enable |
| out_en | output | 1 | Slot output switch enable |

## Verification
Register writes take effect one edge after the cycle in which they are presented. Window enables, `spi_mode`, the supply outputs and the state bits all change on that edge. Removal forcing is also due one edge after `card_present` drops. The power-down return is due on the `OFF_DELAY`-th edge after entry into state 3. The empty flag and read data are combinational, so they are due in the same cycle. The bench advances a behavioural model on each rising edge and compares it with the design 3 ns after that edge. This keeps every comparison after both sides have settled and before the next input change at the falling edge.

// File: rtl/cart_slot_ctl.sv
module cart_slot_ctl #(
  parameter int DW        = 16,
  parameter int OFF_DELAY = 100,
  localparam int CW       = $clog2(OFF_DELAY + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          card_present,
  output logic [2:0]    win_en,
  output logic          spi_mode,
  output logic          reg_en,
  output logic          out_en
);

  typedef enum logic [1:0] {PWR_OFF, PWR_PREP, PWR_ON, PWR_DOWN} pwr_t;

  pwr_t         st_q, st_d;
  logic [1:0]   sel_q;
  logic         spi_q;
  logic [CW-1:0] cnt_q;

  logic ctl_wr, sts_wr, powered, expired;
  pwr_t req;

  assign ctl_wr  = wr_en && !wr_addr;
  assign sts_wr  = wr_en && wr_addr;
  assign req     = pwr_t'(wr_data[3:2]);
  assign powered = (st_q == PWR_PREP) || (st_q == PWR_ON);
  assign expired = (cnt_q == CW'(OFF_DELAY - 1));

  always_comb begin
    st_d = st_q;
    if (powered && !card_present)
      st_d = PWR_DOWN;
    else if (st_q == PWR_DOWN) begin
      if (expired) st_d = PWR_OFF;
    end else if (sts_wr && !(st_q == PWR_OFF && req == PWR_ON))
      st_d = req;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= PWR_OFF;
      sel_q <= 2'd0;
      spi_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= (st_q == PWR_DOWN) ? cnt_q + 1'b1 : '0;
      if (ctl_wr) begin
        sel_q <= wr_data[1:0];
        spi_q <= wr_data[8];
      end
    end
  end

  assign win_en[0] = (sel_q == 2'd0);
  assign win_en[1] = (sel_q == 2'd2);
  assign win_en[2] = (sel_q == 2'd3);
  assign spi_mode  = spi_q;
  assign reg_en    = powered;
  assign out_en    = (st_q == PWR_ON);

  always_comb begin
    rd_data = '0;
    if (rd_addr) begin
      rd_data[0]   = !card_present;
      rd_data[3:2] = st_q;
    end else begin
      rd_data[1:0] = sel_q;
      rd_data[8]   = spi_q;
    end
  end

  logic [CW-1:0] chk_dwell;
  always_ff @(posedge clk) begin
    if (!rst_n) chk_dwell <= '0;
    else        chk_dwell <= (out_en || reg_en || rd_data[1:0] == 2'b11) ? '0 :
                             ((st_q == PWR_DOWN) ? chk_dwell + 1'b1 : '0);
  end

  p_win_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(win_en));
  p_no_skip_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_OFF) |=> (st_q != PWR_ON));
  p_down_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_DOWN) |=> (st_q == PWR_DOWN || st_q == PWR_OFF));
  p_dwell_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PWR_DOWN) |-> (chk_dwell < CW'(OFF_DELAY)));
  p_removal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_en && !card_present) |=> (rd_data[3:2] == 2'd3 || !rd_addr));
  p_switch_r9: assert property (@(posedge clk) disable iff (!rst_n) out_en |-> reg_en);

endmodule

// File: tb/cart_slot_ctl_bench.sv
module cart_slot_ctl_bench;
  localparam int DW = 16;
  localparam int DLY = 12;

  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0, rd_addr = 0, card_present = 1;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic [2:0] win_en;
  logic spi_mode, reg_en, out_en;

  cart_slot_ctl #(.DW(DW), .OFF_DELAY(DLY)) u_cart_slot_ctl (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
    .card_present, .win_en, .spi_mode, .reg_en, .out_en);

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  logic [1:0] m_st = 0, m_sel = 0;
  logic m_spi = 0;
  int m_t = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_sel = 0; m_spi = 0; m_t = 0;
    end else begin
      if ((m_st == 1 || m_st == 2) && !card_present) begin
        m_st = 3; m_t = 0;
      end else if (m_st == 3) begin
        m_t++;
        if (m_t == DLY) m_st = 0;
      end else if (wr_en && wr_addr) begin
        if (!(m_st == 0 && wr_data[3:2] == 2)) begin
          m_st = wr_data[3:2]; m_t = 0;
        end
      end
      if (wr_en && !wr_addr) begin
        m_sel = wr_data[1:0]; m_spi = wr_data[8];
      end
    end
  end

  always @(posedge clk) begin
    logic [2:0] ew;
    logic [DW-1:0] er;
    #3;
    if (rst_n) begin
      ew = (m_sel == 0) ? 3'b001 : (m_sel == 2) ? 3'b010 : (m_sel == 3) ? 3'b100 : 3'b000;
      chk("R1 window", win_en, ew);
      chk("R3 spi", spi_mode, m_spi);
      chk("R9 reg_en", reg_en, (m_st == 1 || m_st == 2));
      chk("R9 out_en", out_en, (m_st == 2));
      er = '0;
      if (rd_addr) begin er[0] = !card_present; er[3:2] = m_st; end
      else begin er[1:0] = m_sel; er[8] = m_spi; end
      chk(rd_addr ? "R5 status" : "R11 control", rd_data, er);
    end
  end

  task automatic wr(logic a, logic [DW-1:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int n3;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 reset window", win_en, 3'b001);
    chk("R10 reset spi", spi_mode, 0);
    rd_addr = 1;
    #1 chk("R10 reset state", rd_data[3:2], 0);

    for (int s = 0; s < 4; s++) begin
      wr(0, DW'(s));
      chk("R2 window after write", win_en, (s == 0) ? 3'b001 : (s == 2) ? 3'b010 : (s == 3) ? 3'b100 : 3'b000);
    end
    wr(0, 16'h0102);
    chk("R3 spi set", spi_mode, 1);
    rd_addr = 0;
    #1 chk("R11 control read", rd_data, 16'h0102);
    rd_addr = 1;

    card_present = 0;
    #1 chk("R4 empty flag", rd_data[0], 1);
    card_present = 1;
    #1 chk("R4 present flag", rd_data[0], 0);

    wr(1, 16'h0008);
    chk("R6 off to on ignored", rd_data[3:2], 0);
    wr(1, 16'h0004);
    chk("R6 prepare", rd_data[3:2], 1);
    chk("R9 regulator in prepare", {reg_en, out_en}, 2'b10);
    wr(1, 16'h0008);
    chk("R6 on", rd_data[3:2], 2);
    chk("R9 switch in on", {reg_en, out_en}, 2'b11);
    wr(1, 16'h000C);
    n3 = 0;
    while (rd_data[3:2] == 3 && n3 < 100) begin
      if (n3 == 3) begin wr_en = 1; wr_addr = 1; wr_data = 16'h0004; @(negedge clk); wr_en = 0; n3++; end
      else begin @(negedge clk); n3++; end
    end
    chk("R7 dwell length", n3, DLY);
    chk("R7 back to off", rd_data[3:2], 0);

    wr(1, 16'h0004);
    wr(1, 16'h0008);
    @(negedge clk); card_present = 0; wr_en = 1; wr_addr = 1; wr_data = 16'h0004;
    @(negedge clk); wr_en = 0;
    chk("R8 forced down", rd_data[3:2], 3);
    idle(DLY + 2);
    chk("R8 off after forced down", rd_data[3:2], 0);
    card_present = 1;
    wr(1, 16'h0004);
    @(negedge clk); card_present = 0;
    @(negedge clk);
    chk("R8 forced from prepare", rd_data[3:2], 3);
    card_present = 1;
    idle(DLY + 2);
    rd_addr = 0;
    idle(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule